// File: doc/BRIEF.md
# Paged EEPROM Write Sequencer

This block is the device-side controller of a byte-wide nonvolatile memory that is written a page at a time. A host drives it like an asynchronous static RAM: an address, a byte of data, and active-low chip select, output enable and write strobe. The three strobes are brought into the system clock domain through two-flop synchronisers, and all edges are detected on the synchronised copies. A write starts when chip select and write strobe are both low while output enable is high. The address is taken when that condition becomes true, and the data is taken when it ends.

Accepted bytes collect in a 32-entry page buffer. A retriggerable load window counts idle clock cycles after each byte. When the window runs out, the block enters a programming interval of fixed length. At the end of that interval the loaded bytes are copied into a register array that stands in for the cell array. While a load or a programming interval is open, any read returns a status byte in place of array data. Throughout programming, a busy output enables the pull-down of an external open-drain pad. After reset, writes are locked out for a fixed number of cycles.

Top module: `pgwr_seq`

## Requirements
- R1: A write is taken only while chip select and write strobe are low and output enable is high. The address is captured when that condition starts and the data when it ends. With output enable low, a low write strobe loads nothing.
- R2: The first accepted byte of a load locks the page, address bits 12..5. Bits 4..0 pick one of 32 byte lanes. During the load, a write to any other page is ignored.
- R3: Each accepted byte restarts a window of LOAD_WIN idle cycles. Programming begins only when a window expires with no newer byte, so bytes spaced closer than the window all join one load.
- R4: Programming lasts exactly PROG_CYC clock cycles. busy_pd_o is 1 for that whole interval and 0 otherwise. Writes issued during programming are ignored and do not start a new load.
- R5: At the end of programming, every lane loaded in this page takes its new byte. Lanes of the page that were not loaded keep their earlier array contents.
- R6: For LOCK_CYC cycles after reset, writes are ignored.
- R7: rdata_oe_o is 1 only while chip select and output enable are low and the write strobe is high. Whenever rdata_oe_o is 0, rdata_o is all zeros. Outside load and programming, a read returns the array byte at the address.
- R8: During a load or programming, a read returns a status byte. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 is a toggle that reads 0 on the first read after the load opens and flips after each read. Bit 5 is 0 during the load window and 1 during programming. Bits 4..0 are 0.
- R9: In reset and right after it, busy_pd_o is 0 and rdata_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 13 | Byte address, page in 12..5, lane in 4..0 |
| wdata_i | input | 8 | Write data from host |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| rdata_o | output | 8 | Read data or status byte |
| rdata_oe_o | output | 1 | Drive enable for the data pads |
| busy_pd_o | output | 1 | Pull-down enable of the open-drain busy pad |

## Verification
A strobe change at the pins reaches the control logic two clock edges later, through the synchronisers. A loaded byte is stored on the third edge after the write strobe rises, so the bench holds write data for four cycles after raising that strobe. Busy rises about LOAD_WIN+3 edges after that rise. It then stays high for exactly PROG_CYC cycles, which a falling-edge monitor counts. Reads sample four falling edges after the strobes drop. All outputs are sampled on falling clock edges, where every register in the path has settled.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOAD = 2'd2,
    ST_PROG = 2'd3
  } pgwr_state_e;
endpackage

// File: rtl/pgwr_sync.sv
module pgwr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int LANE_W   = 5,
  parameter int LOAD_WIN = 20,
  parameter int PROG_CYC = 60,
  parameter int LOCK_CYC = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              d7_i,
  output pgwr_state_e       st_o,
  output logic              buf_wr_o,
  output logic              commit_o,
  output logic [LANE_W-1:0] lane_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              tog_o,
  output logic              last_d7_o,
  output logic              rd_act_o
);
  localparam int MAX_AB = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
  localparam int MAXC   = (MAX_AB > LOCK_CYC) ? MAX_AB : LOCK_CYC;
  localparam int TW     = $clog2(MAXC + 1);

  pgwr_state_e       st_q, st_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              acc_q, acc_d, wr_q, rd_q, tog_q, tog_d, d7_q, d7_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              wr_act, rd_act, wr_start, wr_end, rd_end, expire, accept;

  assign wr_act   = ~ce_s & ~we_s & oe_s;
  assign rd_act   = ~ce_s & ~oe_s & we_s;
  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign rd_end   = ~rd_act & rd_q;
  assign expire   = (st_q == ST_LOAD) && !acc_q && (tmr_q == TW'(LOAD_WIN - 1));
  assign accept   = wr_start && !expire &&
                    ((st_q == ST_IDLE) || ((st_q == ST_LOAD) && (page_i == page_q)));

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_q;
    acc_d    = acc_q;
    page_d   = page_q;
    lane_d   = lane_q;
    tog_d    = tog_q;
    d7_d     = d7_q;
    commit_o = 1'b0;
    buf_wr_o = wr_end & acc_q;
    if (wr_end) acc_d = 1'b0;
    if (buf_wr_o) d7_d = d7_i;
    if (rd_end && ((st_q == ST_LOAD) || (st_q == ST_PROG))) tog_d = ~tog_q;
    if (accept) begin
      acc_d  = 1'b1;
      lane_d = lane_i;
      if (st_q == ST_IDLE) begin
        page_d = page_i;
        st_d   = ST_LOAD;
        tog_d  = 1'b0;
      end
    end
    case (st_q)
      ST_LOCK: begin
        if (tmr_q == TW'(LOCK_CYC - 1)) begin
          st_d  = ST_IDLE;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_IDLE: tmr_d = '0;
      ST_LOAD: begin
        if (expire) begin
          st_d  = ST_PROG;
          tmr_d = '0;
        end else if (accept || acc_q) begin
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_q == TW'(PROG_CYC - 1)) begin
          commit_o = 1'b1;
          st_d     = ST_IDLE;
          tmr_d    = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOCK;
      tmr_q  <= '0;
      acc_q  <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      tog_q  <= 1'b0;
      d7_q   <= 1'b0;
      page_q <= '0;
      lane_q <= '0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      acc_q  <= acc_d;
      wr_q   <= wr_act;
      rd_q   <= rd_act;
      tog_q  <= tog_d;
      d7_q   <= d7_d;
      page_q <= page_d;
      lane_q <= lane_d;
    end
  end

  assign st_o      = st_q;
  assign lane_o    = lane_q;
  assign page_o    = page_q;
  assign tog_o     = tog_q;
  assign last_d7_o = d7_q;
  assign rd_act_o  = rd_act;
endmodule

// File: rtl/pgwr_store.sv
module pgwr_store #(
  parameter int DATA_W   = 8,
  parameter int LANE_W   = 5,
  parameter int ARRAY_AW = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         buf_wr_i,
  input  logic [LANE_W-1:0]            lane_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         commit_i,
  input  logic [ARRAY_AW-LANE_W-1:0]   page_i,
  input  logic [ARRAY_AW-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  localparam int LANES = 1 << LANE_W;
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [DATA_W-1:0] pbuf [LANES];
  logic [DATA_W-1:0] mem  [DEPTH];
  logic [LANES-1:0]  vld_q, vld_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (buf_wr_i && (lane_i == LANE_W'(l))) pbuf[l] <= wdata_i;
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (commit_i) vld_d = '0;
    if (buf_wr_i) vld_d[lane_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (vld_q[l]) mem[{page_i, LANE_W'(l)}] <= pbuf[l];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int LANE_W   = 5,
  parameter int ARRAY_AW = 10,
  parameter int LOAD_WIN = 20,
  parameter int PROG_CYC = 60,
  parameter int LOCK_CYC = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              busy_pd_o
);
  localparam int PAGE_W = ADDR_W - LANE_W;
  localparam int PSEL_W = ARRAY_AW - LANE_W;

  logic [1:0]        rst_q;
  logic              rst_sn;
  logic [2:0]        strb_s;
  pgwr_state_e       st;
  logic              buf_wr, commit, tog, last_d7, rd_act;
  logic [LANE_W-1:0] lane_q;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] arr_rd, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  pgwr_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .d_i  ({ce_n_i, oe_n_i, we_n_i}),
    .q_o  (strb_s)
  );

  pgwr_ctrl #(
    .PAGE_W(PAGE_W), .LANE_W(LANE_W), .LOAD_WIN(LOAD_WIN),
    .PROG_CYC(PROG_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sn),
    .ce_s     (strb_s[2]),
    .oe_s     (strb_s[1]),
    .we_s     (strb_s[0]),
    .page_i   (addr_i[ADDR_W-1:LANE_W]),
    .lane_i   (addr_i[LANE_W-1:0]),
    .d7_i     (wdata_i[DATA_W-1]),
    .st_o     (st),
    .buf_wr_o (buf_wr),
    .commit_o (commit),
    .lane_o   (lane_q),
    .page_o   (page_q),
    .tog_o    (tog),
    .last_d7_o(last_d7),
    .rd_act_o (rd_act)
  );

  pgwr_store #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ARRAY_AW(ARRAY_AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_sn),
    .buf_wr_i (buf_wr),
    .lane_i   (lane_q),
    .wdata_i  (wdata_i),
    .commit_i (commit),
    .page_i   (page_q[PSEL_W-1:0]),
    .rd_addr_i(addr_i[ARRAY_AW-1:0]),
    .rd_data_o(arr_rd)
  );

  always_comb begin
    status             = '0;
    status[DATA_W-1]   = ~last_d7;
    status[DATA_W-2]   = tog;
    status[DATA_W-3]   = (st == ST_PROG);
  end

  assign rdata_oe_o = rd_act;
  assign busy_pd_o  = (st == ST_PROG);
  assign rdata_o    = !rd_act ? '0 :
                      ((st == ST_LOAD) || (st == ST_PROG)) ? status : arr_rd;
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk
  import pgwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              rd_oe,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input pgwr_state_e       st,
  input logic              buf_wr
);
  AST_RD_DRIVE_COND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> ($past(!ce_n, 2) && $past(!oe_n, 2) && $past(we_n, 2))); // R7
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rdata == '0)); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R4
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_wr); // R4
  AST_NO_LOAD_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK) |-> !buf_wr); // R6
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(st) == ST_LOAD)); // R3
  AST_STATUS_TIMER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_oe) |-> rdata[DATA_W-3]); // R8
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_oe) |-> (rdata[DATA_W-4:0] == '0)); // R8
endmodule

bind pgwr_seq pgwr_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sn),
  .ce_n  (ce_n_i),
  .oe_n  (oe_n_i),
  .we_n  (we_n_i),
  .rd_oe (rdata_oe_o),
  .rdata (rdata_o),
  .busy  (busy_pd_o),
  .st    (st),
  .buf_wr(buf_wr)
);

// File: tb/pgwr_seq_tb.sv
`timescale 1ns/1ps
module pgwr_seq_tb;
  localparam int LOAD_WIN = 20;
  localparam int PROG_CYC = 60;
  localparam int LOCK_CYC = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic        ce_n, oe_n, we_n;
  logic [7:0]  rdata;
  logic        rdata_oe, busy;

  int checks = 0;
  int fails  = 0;
  int busy_run = 0;
  int busy_len = 0;
  int wd = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgwr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .busy_pd_o(busy)
  );

  always @(negedge clk) begin
    if (busy) busy_run++;
    else begin
      if (busy_run != 0) busy_len = busy_run;
      busy_run = 0;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1;
    cyc(4);
    ce_n = 1'b1;
    cyc(1);
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(4);
    d = rdata; oe = rdata_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(3);
  endtask

  task automatic rd_chk(input string req, input logic [12:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic oe;
    rd(a, d, oe);
    chk({req, " drive"}, int'(oe), 1);
    chk(req, int'(d), int'(exp));
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!busy && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (busy && n < 400) begin
      @(negedge clk);
      n++;
    end
    cyc(2);
    chk("R4 busy length", busy_len, PROG_CYC);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; wdata = '0;
    cyc(3);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset drive", int'(rdata_oe), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R9 post-reset busy", int'(busy), 0);
  endtask

  task automatic t_single();
    int n;
    wr(13'h045, 8'hA5);
    wait_busy(n);
    chk("R3 window latency ok", int'(n >= LOAD_WIN - 4 && n <= LOAD_WIN + 2), 1);
    rd_chk("R8 status first read", 13'h045, 8'h20);
    rd_chk("R8 status toggled", 13'h100, 8'h60);
    wait_ready();
    rd_chk("R1 single byte stored", 13'h045, 8'hA5);
  endtask

  task automatic t_page();
    int n;
    for (int i = 0; i < 32; i++) wr(13'h020 + 13'(i), 8'h30 + 8'(i * 3));
    wait_busy(n);
    wait_ready();
    for (int i = 0; i < 32; i++) rd_chk("R2 full page", 13'h020 + 13'(i), 8'h30 + 8'(i * 3));
  endtask

  task automatic t_partial();
    int n;
    wr(13'h023, 8'hC3);
    wr(13'h027, 8'hC7);
    wait_busy(n);
    wait_ready();
    for (int i = 0; i < 32; i++) begin
      if (i == 3) rd_chk("R5 loaded lane", 13'h023, 8'hC3);
      else if (i == 7) rd_chk("R5 loaded lane", 13'h027, 8'hC7);
      else rd_chk("R5 unloaded lane kept", 13'h020 + 13'(i), 8'h30 + 8'(i * 3));
    end
  endtask

  task automatic t_offpage();
    int n;
    wr(13'h060, 8'h5A);
    wait_busy(n);
    wait_ready();
    wr(13'h041, 8'h77);
    wr(13'h060, 8'h99);
    wait_busy(n);
    wait_ready();
    rd_chk("R2 locked page byte", 13'h041, 8'h77);
    rd_chk("R2 off-page write ignored", 13'h060, 8'h5A);
  endtask

  task automatic t_retrig();
    int n;
    for (int i = 0; i < 4; i++) begin
      wr(13'h080 + 13'(i), 8'h90 + 8'(i));
      if (i < 3) begin
        cyc(8);
        chk("R3 window retriggered", int'(busy), 0);
      end
    end
    wait_busy(n);
    wait_ready();
    for (int i = 0; i < 4; i++) rd_chk("R3 spaced bytes in one load", 13'h080 + 13'(i), 8'h90 + 8'(i));
  endtask

  task automatic t_loadstat();
    int n;
    wr(13'h0A0, 8'h3C);
    rd_chk("R8 status in load window", 13'h0A0, 8'h80);
    wait_busy(n);
    rd_chk("R8 status in programming", 13'h0A0, 8'hE0);
    wait_ready();
    rd_chk("R7 array read after commit", 13'h0A0, 8'h3C);
  endtask

  task automatic t_busywr();
    int n;
    wr(13'h0C0, 8'h11);
    wait_busy(n);
    wr(13'h0C0, 8'h22);
    wr(13'h0C1, 8'h33);
    wait_ready();
    cyc(LOAD_WIN + 10);
    chk("R4 no load from busy-time write", int'(busy), 0);
    rd_chk("R4 write during programming ignored", 13'h0C0, 8'h11);
  endtask

  task automatic t_bus();
    @(negedge clk);
    addr = 13'h045; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    cyc(4);
    chk("R7 oe high no drive", int'(rdata_oe), 0);
    chk("R7 oe high data zero", int'(rdata), 0);
    ce_n = 1'b1; oe_n = 1'b0;
    cyc(4);
    chk("R7 ce high no drive", int'(rdata_oe), 0);
    wdata = 8'hFF; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    cyc(4);
    chk("R7 strobe low no drive", int'(rdata_oe), 0);
    we_n = 1'b1;
    cyc(4);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(LOAD_WIN + 10);
    chk("R1 no write with oe low", int'(busy), 0);
    rd_chk("R1 byte unchanged", 13'h045, 8'hA5);
  endtask

  task automatic t_lock();
    do_reset();
    wr(13'h045, 8'h00);
    cyc(LOAD_WIN + 40);
    chk("R6 lockout write no busy", int'(busy), 0);
    rd_chk("R6 lockout write ignored", 13'h045, 8'hA5);
  endtask

  initial begin
    do_reset();
    cyc(LOCK_CYC + 5);
    t_single();
    t_page();
    t_partial();
    t_offpage();
    t_retrig();
    t_loadstat();
    t_busywr();
    t_bus();
    t_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule